// File: doc/BRIEF.md
# Chain Conversion Readback Sequencer

This block drives one full conversion-and-readback pass over a daisy chain of battery-monitor devices. On a start pulse it captures the acquisition-time code, the averaging code and the device count. It then asks the external frame transport for two chain-wide register writes. The first sets the read pointer to the first cell channel. The second starts a conversion on every device.

After the second write it waits the conversion time, counted on a 1 µs tick. The wait is computed in hardware from the captured settings. When the wait ends, the block requests one read frame per channel, twelve per device. Every frame whose check value the transport reports as good is passed downstream unchanged on a valid/ready output. The 12-bit results of the cell channels are summed. A single result pulse carries the 32-bit sum and an error flag. A frame reported as bad ends the pass at once, with the error flag set.

Building the write frames and computing the check value on the serial link belong to the transport. The sequencer sees only the write handshake, the read handshake with a check-passed flag, and the tick.

Top module: `chain_scan_sequencer`

## Requirements
- R1: After reset, and whenever no pass is running, `busy`, `wrValid`, `rdReq`, `frmValid` and `resultValid` are all 0.
- R2: The first write of a pass presents `wrReg` = 0x1C and `wrData` = 0x00. It holds `wrValid`, `wrReg` and `wrData` steady until `wrReady` is seen.
- R3: The second write presents `wrReg` = 0x0D and `wrData` = 0x08 | (averaging code << 1). In that byte, bits 7:6 = 0 selects all inputs, bits 5:4 = 0 selects readback of all, bit 3 = 1 starts on chip select, and bits 2:1 hold the averaging code.
- R4: Let tacq be 470, 1030, 1510 or 1945 ns for acquisition codes 0 to 3, and navg be 1, 2, 4 or 8 for averaging codes 0 to 3. Let ns = (tacq + 720) * 12 * navg - tacq + 250 * (devCount - 1), and us = ceil(ns / 1000) + 5. When us < 50, the first `rdReq` follows exactly us `usTick` pulses counted after the second write is accepted.
- R5: When the us of R4 is 50 or more, the first `rdReq` follows exactly 250 `usTick` pulses.
- R6: A pass without error requests exactly 12 * `devCount` frames. It then gives one `resultValid` pulse with `resultErr` = 0. At most one of `wrValid`, `rdReq`, `frmValid` and `resultValid` is high at a time.
- R7: Each frame accepted with `rdCrcOk` = 1 is presented on `frmData` unchanged. `frmValid` and `frmData` hold steady until `frmReady`, and no further read is requested before then.
- R8: `resultSum` is the sum of frame bits 22:11 (the 12-bit result), taken only over frames whose bits 26:23 (the channel address) are 5 or less.
- R9: A frame returned with `rdCrcOk` = 0 is not forwarded. It is followed in the next cycle by `resultValid` with `resultErr` = 1, and no further read is requested.
- R10: `start` is ignored while `busy` is 1. The acquisition code, averaging code and device count are taken at start, and later changes do not affect the running pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a pass when idle |
| acqCode | input | 2 | Acquisition-time code |
| avgCode | input | 2 | Averaging code |
| devCount | input | DEV_W | Devices in the chain, 1 to MAX_DEV |
| usTick | input | 1 | One-cycle pulse every microsecond |
| busy | output | 1 | A pass is running |
| wrValid | output | 1 | Write request to transport |
| wrReady | input | 1 | Transport accepted the write |
| wrReg | output | 6 | Register address of the write |
| wrData | output | 8 | Data byte of the write |
| rdReq | output | 1 | Request for one read frame |
| rdValid | input | 1 | Read frame returned |
| rdFrame | input | 32 | Returned frame |
| rdCrcOk | input | 1 | Returned frame passed its check |
| frmValid | output | 1 | Forwarded frame valid |
| frmReady | input | 1 | Downstream accepts the frame |
| frmData | output | 32 | Forwarded frame |
| resultValid | output | 1 | Pass finished, one cycle |
| resultSum | output | 32 | Sum of cell-channel results |
| resultErr | output | 1 | Pass aborted on a bad frame |

## Verification
The hardest situation to reach is the boundary between the short computed wait and the fixed 250-tick wait, together with the device-spacing term. Only some combinations of acquisition code, averaging code and chain length land on either side of it. The bench therefore sweeps every acquisition and averaging code against every chain length from one to four devices, and counts the ticks between the second write and the first read request. Two targeted passes cover the other hard cases. One injects a failed check in the middle of the chain. The other raises start and changes every setting while the wait is running.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  localparam int FRAME_W        = 32;
  localparam int SUM_W          = 32;
  localparam int FRAMES_PER_DEV = 12;
  localparam int CH_LSB         = 23;
  localparam int CH_W           = 4;
  localparam int DATA_LSB       = 11;
  localparam int DATA_W         = 12;
  localparam int CELL_CH_LAST   = 5;

  localparam logic [5:0] REG_READ_PTR = 6'h1C;
  localparam logic [5:0] REG_CTRL_HI  = 6'h0D;

  localparam int CONV_NS        = 720;
  localparam int DEV_SPACING_NS = 250;
  localparam int NS_PER_US      = 1000;
  localparam int SETTLE_US      = 5;
  localparam int SHORT_LIMIT_US = 50;
  localparam int LONG_WAIT_US   = 250;
  localparam int MAX_ACQ_NS     = 1945;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WR_PTR, ST_WR_CONV, ST_WAIT, ST_READ, ST_PUSH, ST_DONE
  } seqState_t;

  typedef struct packed {
    logic latchCfg;
    logic clearScan;
    logic loadWait;
    logic tickWait;
    logic takeFrame;
    logic setErr;
  } seqStrobe_t;

  function automatic logic [11:0] acqNs(input logic [1:0] code);
    case (code)
      2'd0:    acqNs = 12'd470;
      2'd1:    acqNs = 12'd1030;
      2'd2:    acqNs = 12'd1510;
      default: acqNs = 12'd1945;
    endcase
  endfunction

  // all inputs, readback of all, start on chip select, averaging in 2:1
  function automatic logic [7:0] convCtrlByte(input logic [1:0] avg);
    convCtrlByte = {2'b00, 2'b00, 1'b1, avg, 1'b0};
  endfunction

endpackage

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_seq_pkg::*;
#(
  parameter int MAX_DEV = 8,
  parameter int DEV_W   = $clog2(MAX_DEV + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  seqStrobe_t         strobe,
  input  logic [1:0]         acqCode,
  input  logic [1:0]         avgCode,
  input  logic [DEV_W-1:0]   devCount,
  input  logic [FRAME_W-1:0] rdFrame,
  output logic [1:0]         avgQ,
  output logic               waitDone,
  output logic               framesDone,
  output logic [FRAME_W-1:0] frameQ,
  output logic [SUM_W-1:0]   sumQ,
  output logic               errQ
);

  localparam int NS_MAX  = (MAX_ACQ_NS + CONV_NS) * FRAMES_PER_DEV * 8
                         + DEV_SPACING_NS * MAX_DEV + LONG_WAIT_US * NS_PER_US;
  localparam int NS_W    = $clog2(NS_MAX + 1);
  localparam int CNT_W   = $clog2(FRAMES_PER_DEV * MAX_DEV + 1);
  // ceil(ns/1000) + settle < limit  <=>  ns <= (limit - settle - 1) * 1000
  localparam int SHORT_MAX_NS = (SHORT_LIMIT_US - SETTLE_US - 1) * NS_PER_US;

  logic [1:0]       acqQ;
  logic [DEV_W-1:0] devQ;
  logic [NS_W-1:0]  waitCnt;
  logic [CNT_W-1:0] frameCnt;

  logic [NS_W-1:0]  tacqNs, perConv, convCount, devSpan, waitNs, waitLoad;
  logic [CNT_W-1:0] totalFrames;
  logic [CH_W-1:0]  chField;
  logic [DATA_W-1:0] dataField;

  always_comb begin
    tacqNs    = NS_W'(acqNs(acqQ));
    perConv   = tacqNs + NS_W'(CONV_NS);
    convCount = NS_W'(FRAMES_PER_DEV) << avgQ;
    devSpan   = NS_W'(DEV_SPACING_NS) * NS_W'(devQ - 1'b1);
    waitNs    = perConv * convCount - tacqNs + devSpan;
    waitLoad  = (waitNs <= NS_W'(SHORT_MAX_NS))
              ? waitNs + NS_W'(SETTLE_US * NS_PER_US)
              : NS_W'(LONG_WAIT_US * NS_PER_US);
  end

  assign waitDone    = (waitCnt <= NS_W'(NS_PER_US));
  assign totalFrames = CNT_W'(FRAMES_PER_DEV) * CNT_W'(devQ);
  assign framesDone  = (frameCnt == totalFrames);
  assign chField     = rdFrame[CH_LSB +: CH_W];
  assign dataField   = rdFrame[DATA_LSB +: DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acqQ <= '0;
      avgQ <= '0;
      devQ <= DEV_W'(1);
    end else if (strobe.latchCfg) begin
      acqQ <= acqCode;
      avgQ <= avgCode;
      devQ <= devCount;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waitCnt <= '0;
    end else if (strobe.loadWait) begin
      waitCnt <= waitLoad;
    end else if (strobe.tickWait) begin
      waitCnt <= waitDone ? '0 : waitCnt - NS_W'(NS_PER_US);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frameCnt <= '0;
      frameQ   <= '0;
      sumQ     <= '0;
      errQ     <= 1'b0;
    end else if (strobe.clearScan) begin
      frameCnt <= '0;
      sumQ     <= '0;
      errQ     <= 1'b0;
    end else begin
      if (strobe.takeFrame) begin
        frameCnt <= frameCnt + 1'b1;
        frameQ   <= rdFrame;
        if (chField <= CH_W'(CELL_CH_LAST))
          sumQ <= sumQ + SUM_W'(dataField);
      end
      if (strobe.setErr)
        errQ <= 1'b1;
    end
  end

endmodule

// File: rtl/scan_control.sv
module scan_control
  import scan_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       usTick,
  input  logic       wrReady,
  input  logic       rdValid,
  input  logic       rdCrcOk,
  input  logic       frmReady,
  input  logic [1:0] avgQ,
  input  logic       waitDone,
  input  logic       framesDone,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       wrValid,
  output logic [5:0] wrReg,
  output logic [7:0] wrData,
  output logic       rdReq,
  output logic       frmValid,
  output logic       resultValid
);

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: if (start) begin
        strobe.latchCfg  = 1'b1;
        strobe.clearScan = 1'b1;
        stateNext        = ST_WR_PTR;
      end
      ST_WR_PTR: if (wrReady) stateNext = ST_WR_CONV;
      ST_WR_CONV: if (wrReady) begin
        strobe.loadWait = 1'b1;
        stateNext       = ST_WAIT;
      end
      ST_WAIT: if (usTick) begin
        strobe.tickWait = 1'b1;
        if (waitDone) stateNext = ST_READ;
      end
      ST_READ: if (rdValid) begin
        if (rdCrcOk) begin
          strobe.takeFrame = 1'b1;
          stateNext        = ST_PUSH;
        end else begin
          strobe.setErr = 1'b1;
          stateNext     = ST_DONE;
        end
      end
      ST_PUSH: if (frmReady) stateNext = framesDone ? ST_DONE : ST_READ;
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    busy        = (state != ST_IDLE);
    wrValid     = (state == ST_WR_PTR) || (state == ST_WR_CONV);
    rdReq       = (state == ST_READ);
    frmValid    = (state == ST_PUSH);
    resultValid = (state == ST_DONE);
    wrReg       = (state == ST_WR_CONV) ? REG_CTRL_HI : REG_READ_PTR;
    // read pointer at cell channel 0, shifted into bits 7:2
    wrData      = (state == ST_WR_CONV) ? convCtrlByte(avgQ) : 8'h00;
  end

endmodule

// File: rtl/chain_scan_sequencer.sv
module chain_scan_sequencer
  import scan_seq_pkg::*;
#(
  parameter int MAX_DEV = 8,
  parameter int DEV_W   = $clog2(MAX_DEV + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         acqCode,
  input  logic [1:0]         avgCode,
  input  logic [DEV_W-1:0]   devCount,
  input  logic               usTick,
  output logic               busy,
  output logic               wrValid,
  input  logic               wrReady,
  output logic [5:0]         wrReg,
  output logic [7:0]         wrData,
  output logic               rdReq,
  input  logic               rdValid,
  input  logic [FRAME_W-1:0] rdFrame,
  input  logic               rdCrcOk,
  output logic               frmValid,
  input  logic               frmReady,
  output logic [FRAME_W-1:0] frmData,
  output logic               resultValid,
  output logic [SUM_W-1:0]   resultSum,
  output logic               resultErr
);

  seqStrobe_t strobe;
  logic [1:0] avgQ;
  logic       waitDone;
  logic       framesDone;

  scan_control i_control (
    .clk, .rst_n, .start, .usTick, .wrReady, .rdValid, .rdCrcOk, .frmReady,
    .avgQ, .waitDone, .framesDone, .strobe, .busy, .wrValid, .wrReg, .wrData,
    .rdReq, .frmValid, .resultValid
  );

  scan_datapath #(.MAX_DEV(MAX_DEV), .DEV_W(DEV_W)) i_datapath (
    .clk, .rst_n, .strobe, .acqCode, .avgCode, .devCount, .rdFrame,
    .avgQ, .waitDone, .framesDone,
    .frameQ(frmData), .sumQ(resultSum), .errQ(resultErr)
  );

endmodule

// File: rtl/chain_scan_sequencer_chk.sv
module chain_scan_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        wrValid,
  input logic        wrReady,
  input logic [5:0]  wrReg,
  input logic [7:0]  wrData,
  input logic        rdReq,
  input logic        rdValid,
  input logic        rdCrcOk,
  input logic        frmValid,
  input logic        frmReady,
  input logic [31:0] frmData,
  input logic        resultValid,
  input logic        resultErr
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wrValid && !rdReq && !frmValid && !resultValid); // R1

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wrValid && !wrReady |=> wrValid && $stable(wrReg) && $stable(wrData)); // R2

  AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wrValid, rdReq, frmValid, resultValid})); // R6

  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |=> !resultValid); // R6

  AST_FRM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    frmValid && !frmReady |=> frmValid && $stable(frmData)); // R7

  AST_CRC_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    rdReq && rdValid && !rdCrcOk |=> resultValid && resultErr && !frmValid); // R9

  AST_PASS_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !resultValid |=> busy); // R10

endmodule

bind chain_scan_sequencer chain_scan_sequencer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wrValid(wrValid), .wrReady(wrReady),
  .wrReg(wrReg), .wrData(wrData), .rdReq(rdReq), .rdValid(rdValid),
  .rdCrcOk(rdCrcOk), .frmValid(frmValid), .frmReady(frmReady),
  .frmData(frmData), .resultValid(resultValid), .resultErr(resultErr)
);

// File: tb/test_chain_scan_sequencer.sv
module test_chain_scan_sequencer;

  localparam int MAX_DEV = 4;
  localparam int DEV_W   = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  acqCode = '0;
  logic [1:0]  avgCode = '0;
  logic [DEV_W-1:0] devCount = DEV_W'(1);
  logic        usTick = 1'b0;
  logic        busy, wrValid, rdReq, frmValid, resultValid, resultErr;
  logic        wrReady = 1'b0;
  logic        rdValid = 1'b0;
  logic        rdCrcOk = 1'b1;
  logic        frmReady = 1'b0;
  logic [5:0]  wrReg;
  logic [7:0]  wrData;
  logic [31:0] rdFrame = '0;
  logic [31:0] frmData, resultSum;

  int checks = 0;
  int fails = 0;
  int tickCount = 0;
  bit armed = 1'b0;

  chain_scan_sequencer #(.MAX_DEV(MAX_DEV), .DEV_W(DEV_W)) i_chain_scan_sequencer (
    .clk, .rst_n, .start, .acqCode, .avgCode, .devCount, .usTick, .busy,
    .wrValid, .wrReady, .wrReg, .wrData, .rdReq, .rdValid, .rdFrame, .rdCrcOk,
    .frmValid, .frmReady, .frmData, .resultValid, .resultSum, .resultErr
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // tick every fourth cycle, changed just after the edge
  initial begin
    int phase = 0;
    forever begin
      @(posedge clk);
      #1;
      usTick = (phase == 3);
      phase = (phase + 1) % 4;
    end
  end

  // counts ticks taken by the design between the conversion write and first read
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (armed && !rdReq && usTick) tickCount++;
      if (rdReq) armed = 1'b0;
      if (wrValid && wrReady && wrReg == 6'h0D) begin
        armed = 1'b1;
        tickCount = 0;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic int expTicks(input int acq, input int avg, input int dev);
    int tacq, ns, us;
    case (acq)
      0: tacq = 470;
      1: tacq = 1030;
      2: tacq = 1510;
      default: tacq = 1945;
    endcase
    ns = (tacq + 720) * 12 * (1 << avg) - tacq + 250 * (dev - 1);
    us = (ns + 999) / 1000 + 5;
    return (us < 50) ? us : 250;
  endfunction

  function automatic logic [31:0] mkFrame(input int k, input int acq,
                                          input int avg, input int dev);
    logic [11:0] d;
    d = 12'((k * 37 + acq * 11 + avg * 5 + dev * 3 + 1) & 12'hFFF);
    return {5'(k / 12), 4'(k % 12), d, 11'(k)};
  endfunction

  task automatic doWrite(input logic [5:0] expReg, input logic [7:0] expData,
                         input string req);
    while (!wrValid) @(negedge clk);
    chk(wrReg == expReg, req, "write register", wrReg, expReg);
    chk(wrData == expData, req, "write data", wrData, expData);
    repeat (2) @(negedge clk);
    wrReady = 1'b1;
    @(negedge clk);
    wrReady = 1'b0;
  endtask

  task automatic runScan(input int acq, input int avg, input int dev,
                         input int errAt, input bit disturb);
    int total, expT;
    longint expSum;
    int seenAct;
    total  = 12 * dev;
    expT   = expTicks(acq, avg, dev);
    expSum = 0;
    @(negedge clk);
    acqCode  = 2'(acq);
    avgCode  = 2'(avg);
    devCount = DEV_W'(dev);
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
    doWrite(6'h1C, 8'h00, "R2");
    doWrite(6'h0D, 8'h08 | 8'(avg << 1), "R3");
    if (disturb) begin
      acqCode  = 2'd3;
      avgCode  = 2'd3;
      devCount = DEV_W'(3);
      start    = 1'b1;
      @(negedge clk);
      start    = 1'b0;
    end
    for (int k = 0; k < total; k++) begin
      logic [31:0] f;
      while (!rdReq) @(negedge clk);
      if (k == 0)
        chk(tickCount == expT, (expT < 50) ? "R4" : "R5", "wait ticks",
            tickCount, expT);
      f = mkFrame(k, acq, avg, dev);
      rdFrame = f;
      rdCrcOk = (k != errAt);
      rdValid = 1'b1;
      @(negedge clk);
      rdValid = 1'b0;
      rdCrcOk = 1'b1;
      if (k == errAt) break;
      if (k % 12 <= 5) expSum += f[22:11];
      while (!frmValid) @(negedge clk);
      repeat ((k + acq) % 3) @(negedge clk);
      chk(frmValid && frmData == f, "R7", "forwarded frame", frmData, f);
      frmReady = 1'b1;
      @(negedge clk);
      frmReady = 1'b0;
    end
    while (!resultValid) @(negedge clk);
    if (errAt >= 0) begin
      chk(resultErr == 1'b1, "R9", "error flag", resultErr, 1);
    end else begin
      chk(resultErr == 1'b0, "R6", "error flag", resultErr, 0);
      chk(resultSum == 32'(expSum), "R8", "cell sum", resultSum, expSum);
    end
    seenAct = 0;
    repeat (20) begin
      @(negedge clk);
      if (wrValid || rdReq || frmValid || busy) seenAct++;
    end
    chk(seenAct == 0, disturb ? "R10" : (errAt >= 0 ? "R9" : "R6"),
        "activity after result", seenAct, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !wrValid && !rdReq && !frmValid && !resultValid, "R1",
        "reset outputs", {busy, wrValid, rdReq, frmValid, resultValid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !wrValid && !rdReq, "R1", "idle outputs",
        {busy, wrValid, rdReq}, 0);
    for (int acq = 0; acq < 4; acq++)
      for (int avg = 0; avg < 4; avg++)
        for (int dev = 1; dev <= MAX_DEV; dev++)
          runScan(acq, avg, dev, -1, 1'b0);
    runScan(1, 2, 2, 5, 1'b0);
    runScan(0, 0, 1, -1, 1'b1);
    runScan(2, 1, 3, 0, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule